// File: doc/BRIEF.md
# Micro-Page Translation Buffer with Sibling Fill

This block is a fully associative first-level translation buffer. Each entry maps one 512-byte micro-page, so a 4 KB base page splits into eight micro-page entries. A lookup presents a virtual address. One cycle later the block returns hit or miss, the physical micro-page number and the index of the matching entry. The index is small enough to act as a back pointer for per-entry cache state.

When a lookup misses, the surrounding logic fetches the ordinary 4 KB translation from the next level and presents it on the refill port. The refill names the base virtual page, the base physical page and the micro-page that was demanded. The demanded micro-page entry is written at once and becomes most recently used. The block then fills in the other seven micro-pages of the same base page in the background. It writes one per free cycle, skips any that are already held, and places each one at the least recently used end of the replacement order. Prefetched siblings therefore compete only with the coldest entry, and a streaming pattern no longer takes eight separate misses per base page.

Replacement uses a full age ranking held in hardware. An invalidate port removes every micro-page of a named base page.

Top module: `mpg_tlb`

## Requirements
- R1: After reset no entry is valid, `lk_rsp_valid` and `lk_hit` are low, and any lookup misses.
- R2: A lookup accepted in cycle t (`lk_valid` high) produces `lk_rsp_valid` in cycle t+1 only. `lk_hit` is high exactly when a valid entry's virtual micro-page number equals `lk_vaddr[31:9]`. On a hit, `lk_pmp` is that entry's physical micro-page number and `lk_idx` is its index.
- R3: A refill in cycle t (with `inv_valid` low) stores the micro-page {`rf_vpn`,`rf_sub`} mapped to {`rf_ppn`,`rf_sub`}. A lookup of that micro-page issued in cycle t+1 hits.
- R4: After a refill, the other micro-pages of the same base page are injected in ascending `rf_sub` order, one per free cycle, starting the cycle after the refill. A free cycle is one with no lookup, refill or invalidate.
- R5: Lookups take priority: no sibling is injected in any cycle with `lk_valid` high.
- R6: A sibling micro-page that is already present is not injected again, and its entry keeps its index.
- R7: A newly written entry takes the lowest-index invalid entry if one exists; otherwise it takes the least recently used entry.
- R8: A prefetched sibling is placed at the least recently used position. With the buffer full, each sibling therefore replaces the previous one, and a refill plus its seven siblings displaces exactly two older entries.
- R9: A lookup hit in a cycle with no refill or invalidate moves the hit entry to the most recently used position. A refilled entry also moves to that position.
- R10: An invalidate of base page `inv_vpn` removes all eight micro-page entries of that page, effective for a lookup in the next cycle. It also cancels pending sibling injection for that page. An invalidate cycle makes no other change.
- R11: A refill of a micro-page already present rewrites that entry in place (same index, new physical page) instead of allocating another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| rf_valid | input | 1 | Base-page refill strobe |
| rf_vpn | input | 20 | Base virtual page number of the refill |
| rf_ppn | input | 20 | Base physical page number of the refill |
| rf_sub | input | 3 | Demanded micro-page within the base page |
| inv_valid | input | 1 | Base-page invalidate strobe |
| inv_vpn | input | 20 | Base virtual page to invalidate |
| lk_rsp_valid | output | 1 | Lookup response valid (one cycle after request) |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | 4 | Index of the hitting entry |
| lk_pmp | output | 23 | Physical micro-page number on a hit, zero on a miss |

## Verification
A lookup result is due exactly one edge after the request. The bench drives inputs on the falling edge and reads the response on the following falling edge, and it takes its expectation from a reference model in the state that existed before that edge. A refill becomes visible to the lookup in the very next cycle. Each sibling needs one free cycle, so the bench inserts a counted number of idle cycles before it probes siblings, and it keeps lookups running when it wants to show that injection is held off. Invalidation is checked with a lookup in the cycle right after it.

// File: rtl/mpg_tlb_pkg.sv
package mpg_tlb_pkg;
   typedef enum logic [1:0] {
      AGE_HOLD   = 2'd0,
      AGE_TOUCH  = 2'd1,
      AGE_DEMOTE = 2'd2
   } age_op_e;
endpackage

// File: rtl/mpg_tlb_cam.sv
module mpg_tlb_cam #(
   parameter int ENTRIES = 16,
   parameter int KEY_W   = 23,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic [ENTRIES-1:0]            ent_v,
   input  logic [ENTRIES-1:0][KEY_W-1:0] ent_key,
   input  logic [KEY_W-1:0]              key,
   output logic                          hit,
   output logic [IDX_W-1:0]              hit_idx
);
   logic [ENTRIES-1:0] match;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = ent_v[g] && (ent_key[g] == key);
   end

   always_comb begin
      hit_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) hit_idx = i[IDX_W-1:0];
      end
   end

   assign hit = |match;
endmodule

// File: rtl/mpg_tlb_age.sv
module mpg_tlb_age
   import mpg_tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  age_op_e          op,
   input  logic [IDX_W-1:0] op_idx,
   output logic [IDX_W-1:0] oldest
);
   if (ENTRIES == 1) begin : g_single
      logic unused_age;
      assign unused_age = ^{clk, rst_n, op, op_idx};
      assign oldest = '0;
   end else begin : g_rank
      localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
      logic [ENTRIES-1:0][IDX_W-1:0] rank;
      logic [IDX_W-1:0] pivot;

      assign pivot = rank[op_idx];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) rank[i] <= i[IDX_W-1:0];
         end else begin
            for (int i = 0; i < ENTRIES; i++) begin
               if (op == AGE_TOUCH) begin
                  if (i[IDX_W-1:0] == op_idx)  rank[i] <= '0;
                  else if (rank[i] < pivot)    rank[i] <= rank[i] + 1'b1;
               end else if (op == AGE_DEMOTE) begin
                  if (i[IDX_W-1:0] == op_idx)  rank[i] <= LAST;
                  else if (rank[i] > pivot)    rank[i] <= rank[i] - 1'b1;
               end
            end
         end
      end

      always_comb begin
         oldest = '0;
         for (int i = 0; i < ENTRIES; i++) begin
            if (rank[i] == LAST) oldest = i[IDX_W-1:0];
         end
      end
   end
endmodule

// File: rtl/mpg_tlb_sibq.sv
module mpg_tlb_sibq #(
   parameter int SUB_W = 3,
   parameter int VPN_W = 20,
   parameter int PPN_W = 20,
   localparam int SUBS = 1 << SUB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SUB_W-1:0] start_sub,
   input  logic [VPN_W-1:0] start_vpn,
   input  logic [PPN_W-1:0] start_ppn,
   input  logic             cancel,
   input  logic             advance,
   output logic             busy,
   output logic [SUB_W-1:0] cur_sub,
   output logic [VPN_W-1:0] cur_vpn,
   output logic [PPN_W-1:0] cur_ppn
);
   logic [SUBS-1:0] pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend    <= '0;
         cur_vpn <= '0;
         cur_ppn <= '0;
      end else if (start) begin
         pend    <= ~(SUBS'(1) << start_sub);
         cur_vpn <= start_vpn;
         cur_ppn <= start_ppn;
      end else if (cancel) begin
         pend    <= '0;
      end else if (advance) begin
         pend[cur_sub] <= 1'b0;
      end
   end

   always_comb begin
      cur_sub = '0;
      for (int i = SUBS - 1; i >= 0; i--) begin
         if (pend[i]) cur_sub = i[SUB_W-1:0];
      end
   end

   assign busy = |pend;
endmodule

// File: rtl/mpg_tlb.sv
module mpg_tlb
   import mpg_tlb_pkg::*;
#(
   parameter int ENTRIES    = 16,
   parameter int VA_W       = 32,
   parameter int PA_W       = 32,
   parameter int PAGE_BITS  = 12,
   parameter int MICRO_BITS = 9,
   localparam int VMP_W = VA_W - MICRO_BITS,
   localparam int PMP_W = PA_W - MICRO_BITS,
   localparam int VPN_W = VA_W - PAGE_BITS,
   localparam int PPN_W = PA_W - PAGE_BITS,
   localparam int SUB_W = PAGE_BITS - MICRO_BITS,
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [VA_W-1:0]  lk_vaddr,
   input  logic             rf_valid,
   input  logic [VPN_W-1:0] rf_vpn,
   input  logic [PPN_W-1:0] rf_ppn,
   input  logic [SUB_W-1:0] rf_sub,
   input  logic             inv_valid,
   input  logic [VPN_W-1:0] inv_vpn,
   output logic             lk_rsp_valid,
   output logic             lk_hit,
   output logic [IDX_W-1:0] lk_idx,
   output logic [PMP_W-1:0] lk_pmp
);
   if (MICRO_BITS < 1 || MICRO_BITS >= PAGE_BITS) begin : g_bad_micro
      $error("mpg_tlb: MICRO_BITS must lie between 1 and PAGE_BITS-1");
   end
   if (PAGE_BITS >= VA_W || PAGE_BITS >= PA_W) begin : g_bad_page
      $error("mpg_tlb: PAGE_BITS must be narrower than both address widths");
   end
   if (ENTRIES < 2) begin : g_bad_depth
      $error("mpg_tlb: ENTRIES must be at least 2");
   end

   logic [ENTRIES-1:0]            ent_v;
   logic [ENTRIES-1:0][VMP_W-1:0] ent_vmp;
   logic [ENTRIES-1:0][PMP_W-1:0] ent_pmp;

   logic             sq_busy;
   logic [SUB_W-1:0] sq_sub;
   logic [VPN_W-1:0] sq_vpn;
   logic [PPN_W-1:0] sq_ppn;

   logic             lk_m, pr_m;
   logic [IDX_W-1:0] lk_mi, pr_mi, old_idx, free_idx, vic_idx, wr_idx;
   logic [VMP_W-1:0] pr_key;
   logic [PMP_W-1:0] wr_pmp;
   logic             has_free, do_rf, do_touch, do_pf, pf_ins, wr_en;
   logic [ENTRIES-1:0] we_vec, inv_hit;
   age_op_e          age_op;
   logic [IDX_W-1:0] age_idx;
   logic             unused_low;

   assign unused_low = ^lk_vaddr[MICRO_BITS-1:0];

   mpg_tlb_cam #(.ENTRIES(ENTRIES), .KEY_W(VMP_W)) u_cam_lk (
      .ent_v(ent_v), .ent_key(ent_vmp), .key(lk_vaddr[VA_W-1:MICRO_BITS]),
      .hit(lk_m), .hit_idx(lk_mi));

   assign pr_key = rf_valid ? {rf_vpn, rf_sub} : {sq_vpn, sq_sub};

   mpg_tlb_cam #(.ENTRIES(ENTRIES), .KEY_W(VMP_W)) u_cam_pr (
      .ent_v(ent_v), .ent_key(ent_vmp), .key(pr_key),
      .hit(pr_m), .hit_idx(pr_mi));

   mpg_tlb_age #(.ENTRIES(ENTRIES)) u_age (
      .clk(clk), .rst_n(rst_n), .op(age_op), .op_idx(age_idx), .oldest(old_idx));

   assign do_rf    = rf_valid & ~inv_valid;
   assign do_touch = lk_valid & lk_m & ~inv_valid & ~rf_valid;
   assign do_pf    = sq_busy & ~inv_valid & ~rf_valid & ~lk_valid;
   assign pf_ins   = do_pf & ~pr_m;

   mpg_tlb_sibq #(.SUB_W(SUB_W), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_sibq (
      .clk(clk), .rst_n(rst_n),
      .start(do_rf), .start_sub(rf_sub), .start_vpn(rf_vpn), .start_ppn(rf_ppn),
      .cancel(inv_valid && (sq_vpn == inv_vpn)), .advance(do_pf),
      .busy(sq_busy), .cur_sub(sq_sub), .cur_vpn(sq_vpn), .cur_ppn(sq_ppn));

   always_comb begin
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!ent_v[i]) free_idx = i[IDX_W-1:0];
      end
   end
   assign has_free = ~&ent_v;
   assign vic_idx  = has_free ? free_idx : old_idx;

   assign wr_en  = do_rf | pf_ins;
   assign wr_idx = (do_rf && pr_m) ? pr_mi : vic_idx;
   assign wr_pmp = do_rf ? {rf_ppn, rf_sub} : {sq_ppn, sq_sub};

   always_comb begin
      age_op  = AGE_HOLD;
      age_idx = wr_idx;
      if (do_rf) begin
         age_op = AGE_TOUCH;
      end else if (do_touch) begin
         age_op  = AGE_TOUCH;
         age_idx = lk_mi;
      end else if (pf_ins) begin
         age_op = AGE_DEMOTE;
      end
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign we_vec[g]  = wr_en && (wr_idx == g[IDX_W-1:0]);
      assign inv_hit[g] = inv_valid && (ent_vmp[g][VMP_W-1:SUB_W] == inv_vpn);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_v[g]   <= 1'b0;
            ent_vmp[g] <= '0;
            ent_pmp[g] <= '0;
         end else if (inv_hit[g]) begin
            ent_v[g]   <= 1'b0;
         end else if (we_vec[g]) begin
            ent_v[g]   <= 1'b1;
            ent_vmp[g] <= pr_key;
            ent_pmp[g] <= wr_pmp;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lk_rsp_valid <= 1'b0;
         lk_hit       <= 1'b0;
         lk_idx       <= '0;
         lk_pmp       <= '0;
      end else begin
         lk_rsp_valid <= lk_valid;
         lk_hit       <= lk_valid & lk_m;
         lk_idx       <= lk_mi;
         lk_pmp       <= (lk_valid && lk_m) ? ent_pmp[lk_mi] : '0;
      end
   end
endmodule

// File: rtl/mpg_tlb_chk.sv
module mpg_tlb_chk #(
   parameter int VA_W       = 32,
   parameter int PA_W       = 32,
   parameter int PAGE_BITS  = 12,
   parameter int MICRO_BITS = 9,
   localparam int PMP_W = PA_W - MICRO_BITS,
   localparam int VPN_W = VA_W - PAGE_BITS,
   localparam int PPN_W = PA_W - PAGE_BITS,
   localparam int SUB_W = PAGE_BITS - MICRO_BITS
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic [VA_W-1:0]  lk_vaddr,
   input logic             rf_valid,
   input logic [VPN_W-1:0] rf_vpn,
   input logic [PPN_W-1:0] rf_ppn,
   input logic [SUB_W-1:0] rf_sub,
   input logic             inv_valid,
   input logic [VPN_W-1:0] inv_vpn,
   input logic             lk_rsp_valid,
   input logic             lk_hit,
   input logic [PMP_W-1:0] lk_pmp
);
   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!lk_rsp_valid && !lk_hit));

   a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> lk_rsp_valid);

   a_r2_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> (!lk_rsp_valid && !lk_hit));

   a_r3_refill_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_valid && !inv_valid) ##1
      (lk_valid && lk_vaddr[VA_W-1:MICRO_BITS] == {$past(rf_vpn), $past(rf_sub)})
      |=> (lk_hit && lk_pmp == {$past(rf_ppn, 2), $past(rf_sub, 2)}));

   a_r10_inv_removes_page: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid ##1 (lk_valid && lk_vaddr[VA_W-1:PAGE_BITS] == $past(inv_vpn))
      |=> !lk_hit);
endmodule

bind mpg_tlb mpg_tlb_chk #(
   .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .MICRO_BITS(MICRO_BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
   .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_sub(rf_sub),
   .inv_valid(inv_valid), .inv_vpn(inv_vpn),
   .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit), .lk_pmp(lk_pmp)
);

// File: tb/mpg_tlb_tb_top.sv
module mpg_tlb_tb_top;
   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic        rf_valid = 1'b0;
   logic [19:0] rf_vpn = '0, rf_ppn = '0;
   logic [2:0]  rf_sub = '0;
   logic        inv_valid = 1'b0;
   logic [19:0] inv_vpn = '0;
   logic        lk_rsp_valid, lk_hit;
   logic [3:0]  lk_idx;
   logic [22:0] lk_pmp;

   always #10 clk = ~clk;

   mpg_tlb dut_i (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
      .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_sub(rf_sub),
      .inv_valid(inv_valid), .inv_vpn(inv_vpn),
      .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_pmp(lk_pmp));

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // reference model
   bit          mv [N];
   logic [22:0] mvmp [N];
   logic [22:0] mpmp [N];
   int          ord [N];
   logic [7:0]  pend;
   logic [19:0] pvpn, pppn;

   int          last_idx;
   logic [22:0] last_pmp;
   bit          last_hit;

   function automatic int m_find(input logic [22:0] k);
      for (int i = 0; i < N; i++) if (mv[i] && mvmp[i] == k) return i;
      return -1;
   endfunction

   function automatic int m_victim();
      for (int i = 0; i < N; i++) if (!mv[i]) return i;
      return ord[N-1];
   endfunction

   function automatic void m_touch(input int e);
      int p = 0;
      for (int i = 0; i < N; i++) if (ord[i] == e) p = i;
      for (int i = p; i > 0; i--) ord[i] = ord[i-1];
      ord[0] = e;
   endfunction

   function automatic void m_demote(input int e);
      int p = 0;
      for (int i = 0; i < N; i++) if (ord[i] == e) p = i;
      for (int i = p; i < N - 1; i++) ord[i] = ord[i+1];
      ord[N-1] = e;
   endfunction

   function automatic void m_reset();
      for (int i = 0; i < N; i++) begin
         mv[i] = 1'b0; mvmp[i] = '0; mpmp[i] = '0; ord[i] = i;
      end
      pend = '0; pvpn = '0; pppn = '0;
   endfunction

   function automatic void m_cycle(input bit lk, input logic [22:0] lkey,
                                   input bit rf, input logic [19:0] rv,
                                   input logic [19:0] rp, input logic [2:0] rs,
                                   input bit iv, input logic [19:0] ivp);
      int h, s, v;
      if (iv) begin
         for (int i = 0; i < N; i++) if (mvmp[i][22:3] == ivp) mv[i] = 1'b0;
         if (pvpn == ivp) pend = '0;
      end else if (rf) begin
         h = m_find({rv, rs});
         v = (h >= 0) ? h : m_victim();
         mv[v] = 1'b1; mvmp[v] = {rv, rs}; mpmp[v] = {rp, rs};
         m_touch(v);
         pend = 8'hFF; pend[rs] = 1'b0; pvpn = rv; pppn = rp;
      end else if (lk) begin
         h = m_find(lkey);
         if (h >= 0) m_touch(h);
      end else if (pend != 0) begin
         s = 0;
         for (int i = 7; i >= 0; i--) if (pend[i]) s = i;
         pend[s] = 1'b0;
         if (m_find({pvpn, 3'(s)}) < 0) begin
            v = m_victim();
            mv[v] = 1'b1; mvmp[v] = {pvpn, 3'(s)}; mpmp[v] = {pppn, 3'(s)};
            m_demote(v);
         end
      end
   endfunction

   task automatic fail_line(input string req, input string what,
                            input longint act, input longint exp);
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) fail_line(req, what, act, exp);
   endtask

   // one clock: model expectation before the edge, compare after it
   task automatic step(input int hand, input string req);
      int eh;
      logic [22:0] lkey;
      bit was_lk;
      lkey = lk_vaddr[31:9];
      was_lk = lk_valid;
      eh = m_find(lkey);
      @(posedge clk);
      m_cycle(lk_valid, lkey, rf_valid, rf_vpn, rf_ppn, rf_sub, inv_valid, inv_vpn);
      @(negedge clk);
      lk_valid = 1'b0; rf_valid = 1'b0; inv_valid = 1'b0;
      if (was_lk) begin
         last_hit = lk_hit; last_idx = int'(lk_idx); last_pmp = lk_pmp;
         chk(lk_rsp_valid == 1'b1, "R2", "rsp_valid", lk_rsp_valid, 1);
         chk(lk_hit == (eh >= 0), req, "hit vs model", lk_hit, eh >= 0);
         if (eh >= 0) begin
            chk(int'(lk_idx) == eh, req, "idx vs model", lk_idx, eh);
            chk(lk_pmp == mpmp[eh], req, "pmp vs model", lk_pmp, mpmp[eh]);
         end
         if (hand >= 0) chk(lk_hit == hand[0], req, "hit expected", lk_hit, hand);
      end
   endtask

   function automatic logic [31:0] va(input logic [19:0] vpn, input logic [2:0] sub);
      return {vpn, sub, 9'h1C4};
   endfunction

   task automatic lkp(input logic [31:0] a, input int hand, input string req);
      lk_valid = 1'b1; lk_vaddr = a;
      step(hand, req);
   endtask

   task automatic refill(input logic [19:0] v, input logic [19:0] p, input logic [2:0] s);
      rf_valid = 1'b1; rf_vpn = v; rf_ppn = p; rf_sub = s;
      step(-1, "R3");
   endtask

   task automatic inval(input logic [19:0] v);
      inv_valid = 1'b1; inv_vpn = v;
      step(-1, "R10");
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(-1, "R4");
   endtask

   localparam logic [19:0] PA = 20'h00010, PB = 20'h00020, PC = 20'h00030,
                           PG = 20'h00040, PH = 20'h00050, PD = 20'h00060,
                           PE = 20'h00070;

   task automatic t_reset();
      chk(lk_rsp_valid == 1'b0 && lk_hit == 1'b0, "R1", "reset outputs",
          {lk_rsp_valid, lk_hit}, 0);
      lkp(va(PA, 0), 0, "R1");
   endtask

   task automatic t_demand_and_priority();
      refill(PA, 20'h00AB0, 3'd3);
      lkp(va(PA, 3), 1, "R3");
      chk(last_pmp == {20'h00AB0, 3'd3}, "R3", "pmp", last_pmp, {20'h00AB0, 3'd3});
      for (int i = 0; i < 8; i++) lkp(va(PA, 4), 0, "R5");
      idle(7);
      for (int s = 0; s < 8; s++) begin
         lkp(va(PA, 3'(s)), 1, "R2");
         chk(last_pmp == {20'h00AB0, 3'(s)}, "R2", "sibling pmp", last_pmp,
             {20'h00AB0, 3'(s)});
      end
   endtask

   task automatic t_order();
      refill(PB, 20'h00BB0, 3'd5);
      idle(1);
      lkp(va(PB, 0), 1, "R4");
      lkp(va(PB, 1), 0, "R4");
      idle(6);
      lkp(va(PB, 7), 1, "R4");
   endtask

   task automatic t_full_prefetch();
      int hits = 0;
      refill(PC, 20'h00CC0, 3'd0);
      idle(7);
      lkp(va(PC, 7), 1, "R8");
      lkp(va(PC, 3), 0, "R8");
      lkp(va(PC, 0), 1, "R8");
      for (int s = 0; s < 8; s++) begin
         lkp(va(PA, 3'(s)), -1, "R8"); hits += int'(last_hit);
         lkp(va(PB, 3'(s)), -1, "R8"); hits += int'(last_hit);
      end
      chk(hits == 14, "R8", "older survivors", hits, 14);
   endtask

   task automatic t_touch();
      logic [22:0] k;
      k = mvmp[ord[N-1]];
      lkp({k, 9'h0}, 1, "R9");
      refill(PG, 20'h00DD0, 3'd0);
      lkp({k, 9'h0}, 1, "R9");
      idle(7);
      lkp({k, 9'h0}, 1, "R9");
   endtask

   task automatic t_no_dup();
      int first;
      refill(PH, 20'h00EE0, 3'd6);
      refill(PH, 20'h00EE0, 3'd1);
      lkp(va(PH, 6), 1, "R6");
      first = last_idx;
      idle(8);
      lkp(va(PH, 6), 1, "R6");
      chk(last_idx == first, "R6", "index kept", last_idx, first);
   endtask

   task automatic t_invalidate();
      inval(PA);
      for (int s = 0; s < 8; s++) lkp(va(PA, 3'(s)), 0, "R10");
      refill(PD, 20'h00F10, 3'd0);
      lkp(va(PD, 0), 1, "R7");
      refill(PE, 20'h00F20, 3'd0);
      inval(PE);
      idle(8);
      lkp(va(PE, 5), 0, "R10");
      lkp(va(PE, 0), 0, "R10");
   endtask

   task automatic t_rewrite();
      int first;
      lkp(va(PD, 0), 1, "R11");
      first = last_idx;
      refill(PD, 20'h00F99, 3'd0);
      lkp(va(PD, 0), 1, "R11");
      chk(last_idx == first, "R11", "same index", last_idx, first);
      chk(last_pmp == {20'h00F99, 3'd0}, "R11", "new pmp", last_pmp, {20'h00F99, 3'd0});
   endtask

   initial begin
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_demand_and_priority();
      t_order();
      t_full_prefetch();
      t_touch();
      t_no_dup();
      t_invalidate();
      t_rewrite();
      idle(2);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule